// File: doc/BRIEF.md
# Per-Slice Register Port Budget Checker

The register file is split into several slices. Each slice has its own small budget of shared read ports and shared write ports per scheduling cycle. The checker looks at one candidate access at a time. A candidate carries up to three operands, each with a register number and a slice number. A read candidate also carries one flag per operand that marks a value taken from the bypass buffer. The checker answers at once whether the access fits in what is left of every touched slice's budget. When the access is performed, its cost is added to the per-slice usage counters. A window-end strobe marks the end of a scheduling cycle and returns all counters to zero.

An operand costs a shared port only when it is not exempt. A read is exempt when its register is wired to a dedicated read port, or when its value comes from the bypass buffer. A write is exempt when its register is wired to a dedicated write port. The limits, the unlimited switches and the two dedicated-register masks are parameters.

Several candidates may be checked and committed inside one window, one per clock. Each check sees the counters as left by the commits made earlier in that window. This is a check/commit pair, not a stream:
- `req_fit` is a combinational answer that consumes nothing.
- `req_take` is the caller's statement that the access has happened. It applies only when `req_fit` is high.

Nothing is buffered, and there is no back-pressure beyond `req_fit`.

Top module: `port_budget_chk`

## Requirements
- R1: A valid read operand costs one shared read port in its slice (`op_slice` value s selects slice s) unless its register's bit in the read-dedicated mask is set or its `op_bypass` bit is high.
- R2: A valid write operand costs one shared write port in its slice unless its register's bit in the write-dedicated mask is set; `op_bypass` has no effect on writes.
- R3: `req_fit` is high only if, in every slice, the committed usage plus the candidate's cost in that slice does not exceed the per-slice limit; slices are budgeted independently.
- R4: Read usage and write usage are kept in separate counters; committed reads do not reduce the write budget and the reverse.
- R5: With the unlimited setting for an access type, every valid request of that type fits, whatever has been committed.
- R6: Usage counters change only at a clock edge where `req_valid`, `req_fit` and `req_take` are all high; checking alone, or `req_take` without a fit, consumes nothing.
- R7: At a clock edge with `win_end` high, all read and write counters of all slices become zero, including any commit made in that same cycle.
- R8: A limit of zero blocks every access that has a non-exempt operand, while an access whose operands are all exempt still fits.
- R9: `req_fit` is low while `req_valid` is low, and operands whose `op_valid` bit is low cost nothing.
- R10: A commit takes effect for checks made from the next clock cycle on; the check in the commit cycle uses the counters from before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears all counters |
| win_end | input | 1 | Last clock of the scheduling window; counters clear at this edge |
| req_valid | input | 1 | A candidate access is presented |
| req_is_write | input | 1 | 0 = read access, 1 = write access |
| op_valid | input | NOPS | Per-operand presence bits |
| op_reg | input | NOPS*REG_W | Per-operand register number |
| op_slice | input | NOPS*SL_W | Per-operand slice number |
| op_bypass | input | NOPS | Per-operand bypass-buffer flag (reads only) |
| req_take | input | 1 | The access is performed this cycle (acts only with `req_fit`) |
| req_fit | output | 1 | The candidate fits in the remaining budget |

## Verification
The bench builds three copies of the block, and all three see the same stimulus. The first uses the default four slices, 2 read and 1 write port per slice, registers 0 and 1 as read-dedicated and register 15 as write-dedicated. This copy brings budget exhaustion, cross-slice independence and both kinds of exemption within a few commits. A second copy has both limits set to zero, which makes the all-exempt-versus-blocked boundary of R8 reachable on every request. A third copy has both types unlimited, so R5 is checked while committed usage piles up far beyond any finite budget.

// File: rtl/port_budget_pkg.sv
package port_budget_pkg;
  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/pbc_slice_demand.sv
// Turns the operand list into a per-slice count of shared ports needed.
module pbc_slice_demand
  import port_budget_pkg::*;
#(
  parameter int NOPS  = 3,
  parameter int NREGS = 16,
  parameter int NSL   = 4,
  parameter logic [NREGS-1:0] RD_DED = '0,
  parameter logic [NREGS-1:0] WR_DED = '0,
  localparam int REG_W = $clog2(NREGS),
  localparam int SL_W  = (NSL > 1) ? $clog2(NSL) : 1,
  localparam int DW    = $clog2(NOPS + 1)
) (
  input  logic                          is_write,
  input  logic [NOPS-1:0]               op_valid,
  input  logic [NOPS-1:0][REG_W-1:0]    op_reg,
  input  logic [NOPS-1:0][SL_W-1:0]     op_slice,
  input  logic [NOPS-1:0]               op_bypass,
  output logic [NSL-1:0][DW-1:0]        demand
);
  logic [NOPS-1:0] op_cost;

  always_comb begin
    for (int i = 0; i < NOPS; i++) begin
      if (acc_kind_e'(is_write) == ACC_WRITE)
        op_cost[i] = op_valid[i] & ~WR_DED[op_reg[i]];
      else
        op_cost[i] = op_valid[i] & ~RD_DED[op_reg[i]] & ~op_bypass[i];
    end
  end

  for (genvar s = 0; s < NSL; s++) begin : g_slice
    always_comb begin
      demand[s] = '0;
      for (int i = 0; i < NOPS; i++) begin
        if (op_cost[i] && (int'(op_slice[i]) == s))
          demand[s] = demand[s] + DW'(1);
      end
    end
  end

  // R9: an empty operand list asks nothing of any slice
  always_comb begin
    if (op_valid == '0)
      assert_empty_costs_nothing_R9: assert (demand == '0);
  end
endmodule

// File: rtl/pbc_slice_budget.sv
// One slice: read/write usage counters and the fit decision for that slice.
module pbc_slice_budget #(
  parameter int NOPS     = 3,
  parameter int RD_LIMIT = 2,
  parameter int WR_LIMIT = 1,
  parameter bit RD_UNLIM = 1'b0,
  parameter bit WR_UNLIM = 1'b0,
  parameter int CNT_W    = 3,
  localparam int DW      = $clog2(NOPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] demand,
  input  logic          is_write,
  input  logic          commit,
  input  logic          win_end,
  output logic          fit
);
  localparam logic [CNT_W:0] RD_LIM_V = (CNT_W + 1)'(RD_LIMIT);
  localparam logic [CNT_W:0] WR_LIM_V = (CNT_W + 1)'(WR_LIMIT);
  localparam logic [CNT_W:0] SAT_V    = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] rd_used, wr_used;
  logic [CNT_W:0]   rd_sum, wr_sum;
  logic             rd_ok, wr_ok;

  assign rd_sum = {1'b0, rd_used} + (CNT_W + 1)'(demand);
  assign wr_sum = {1'b0, wr_used} + (CNT_W + 1)'(demand);
  assign rd_ok  = RD_UNLIM || (rd_sum <= RD_LIM_V);
  assign wr_ok  = WR_UNLIM || (wr_sum <= WR_LIM_V);
  assign fit    = is_write ? wr_ok : rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_used <= '0;
      wr_used <= '0;
    end else if (win_end) begin
      rd_used <= '0;
      wr_used <= '0;
    end else if (commit) begin
      if (is_write)
        wr_used <= (wr_sum > SAT_V) ? SAT_V[CNT_W-1:0] : wr_sum[CNT_W-1:0];
      else
        rd_used <= (rd_sum > SAT_V) ? SAT_V[CNT_W-1:0] : rd_sum[CNT_W-1:0];
    end
  end

  if (!RD_UNLIM) begin : g_rd_bound
    assert_read_within_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, rd_used} <= RD_LIM_V);
  end
  if (!WR_UNLIM) begin : g_wr_bound
    assert_write_within_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, wr_used} <= WR_LIM_V);
  end

  assert_window_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (rd_used == '0) && (wr_used == '0));

  assert_hold_without_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !win_end) |=> ($stable(rd_used) && $stable(wr_used)));

  assert_zero_cost_fits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (demand == '0) |-> fit);
endmodule

// File: rtl/port_budget_chk.sv
module port_budget_chk
  import port_budget_pkg::*;
#(
  parameter int NOPS     = 3,
  parameter int NREGS    = 16,
  parameter int NSL      = 4,
  parameter int RD_LIMIT = 2,
  parameter int WR_LIMIT = 1,
  parameter bit RD_UNLIM = 1'b0,
  parameter bit WR_UNLIM = 1'b0,
  parameter int CNT_W    = 3,
  parameter logic [NREGS-1:0] RD_DED = 16'h0003,
  parameter logic [NREGS-1:0] WR_DED = 16'h8000,
  localparam int REG_W = $clog2(NREGS),
  localparam int SL_W  = (NSL > 1) ? $clog2(NSL) : 1,
  localparam int DW    = $clog2(NOPS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       win_end,
  input  logic                       req_valid,
  input  logic                       req_is_write,
  input  logic [NOPS-1:0]            op_valid,
  input  logic [NOPS-1:0][REG_W-1:0] op_reg,
  input  logic [NOPS-1:0][SL_W-1:0]  op_slice,
  input  logic [NOPS-1:0]            op_bypass,
  input  logic                       req_take,
  output logic                       req_fit
);
  logic [NSL-1:0][DW-1:0] demand;
  logic [NSL-1:0]         slice_fit;
  logic                   commit;

  pbc_slice_demand #(
    .NOPS(NOPS), .NREGS(NREGS), .NSL(NSL), .RD_DED(RD_DED), .WR_DED(WR_DED)
  ) u_demand (
    .is_write (req_is_write),
    .op_valid (op_valid),
    .op_reg   (op_reg),
    .op_slice (op_slice),
    .op_bypass(op_bypass),
    .demand   (demand)
  );

  for (genvar s = 0; s < NSL; s++) begin : g_budget
    pbc_slice_budget #(
      .NOPS(NOPS), .RD_LIMIT(RD_LIMIT), .WR_LIMIT(WR_LIMIT),
      .RD_UNLIM(RD_UNLIM), .WR_UNLIM(WR_UNLIM), .CNT_W(CNT_W)
    ) u_budget (
      .clk     (clk),
      .rst_n   (rst_n),
      .demand  (demand[s]),
      .is_write(req_is_write),
      .commit  (commit),
      .win_end (win_end),
      .fit     (slice_fit[s])
    );
  end

  assign req_fit = req_valid & (&slice_fit);
  assign commit  = req_fit & req_take;

  // R5: an unlimited access type is never refused
  if (RD_UNLIM && WR_UNLIM) begin : g_free
    assert_unlimited_always_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_fit);
  end
endmodule

// File: tb/port_budget_chk_tb.sv
module port_budget_chk_tb;
  localparam int NOPS = 3, NREGS = 16, NSL = 4;
  localparam logic [15:0] RDD = 16'h0003, WRD = 16'h8000;
  localparam int LIM_RD = 2, LIM_WR = 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, win_end, req_valid, req_is_write, req_take;
  logic [NOPS-1:0] op_valid, op_bypass;
  logic [NOPS-1:0][3:0] op_reg;
  logic [NOPS-1:0][1:0] op_slice;
  logic fit_main, fit_zero, fit_free;

  port_budget_chk #(.RD_DED(RDD), .WR_DED(WRD)) u_dut (
    .clk, .rst_n, .win_end, .req_valid, .req_is_write, .op_valid, .op_reg,
    .op_slice, .op_bypass, .req_take, .req_fit(fit_main));
  port_budget_chk #(.RD_LIMIT(0), .WR_LIMIT(0), .RD_DED(RDD), .WR_DED(WRD)) u_dut_zero (
    .clk, .rst_n, .win_end, .req_valid, .req_is_write, .op_valid, .op_reg,
    .op_slice, .op_bypass, .req_take, .req_fit(fit_zero));
  port_budget_chk #(.RD_UNLIM(1'b1), .WR_UNLIM(1'b1), .RD_DED(RDD), .WR_DED(WRD)) u_dut_free (
    .clk, .rst_n, .win_end, .req_valid, .req_is_write, .op_valid, .op_reg,
    .op_slice, .op_bypass, .req_take, .req_fit(fit_free));

  int total = 0, bad = 0;
  int m_rd[NSL], m_wr[NSL];
  bit finished = 1'b0;

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic int cost(int s);
    int d = 0;
    for (int i = 0; i < NOPS; i++) begin
      if (op_valid[i] && int'(op_slice[i]) == s) begin
        if (req_is_write) begin
          if (!WRD[op_reg[i]]) d++;
        end else if (!RDD[op_reg[i]] && !op_bypass[i]) d++;
      end
    end
    return d;
  endfunction

  function automatic bit ref_fit(int lrd, int lwr, bit unlim, bit use_cnt);
    if (!req_valid) return 1'b0;
    if (unlim) return 1'b1;
    for (int s = 0; s < NSL; s++) begin
      int used = use_cnt ? (req_is_write ? m_wr[s] : m_rd[s]) : 0;
      if (used + cost(s) > (req_is_write ? lwr : lrd)) return 1'b0;
    end
    return 1'b1;
  endfunction

  // exp: 0/1 explicit expectation for u_dut, -1 = use reference model
  task automatic apply(input bit v, input bit wr, input logic [2:0] ov,
                       input logic [3:0] r0, input logic [3:0] r1, input logic [3:0] r2,
                       input logic [1:0] s0, input logic [1:0] s1, input logic [1:0] s2,
                       input logic [2:0] byp, input bit take, input bit win,
                       input int exp, input string tag);
    bit mf;
    @(negedge clk);
    req_valid = v; req_is_write = wr; op_valid = ov;
    op_reg = {r2, r1, r0}; op_slice = {s2, s1, s0}; op_bypass = byp;
    req_take = take; win_end = win;
    #1;
    mf = ref_fit(LIM_RD, LIM_WR, 1'b0, 1'b1);
    chk(fit_main, (exp < 0) ? mf : exp[0], tag);
    chk(fit_zero, ref_fit(0, 0, 1'b0, 1'b0), {tag, " zero-limit R8"});
    chk(fit_free, ref_fit(0, 0, 1'b1, 1'b0), {tag, " unlimited R5"});
    if (mf && take) begin
      for (int s = 0; s < NSL; s++) begin
        if (wr) m_wr[s] += cost(s); else m_rd[s] += cost(s);
      end
    end
    if (win) begin
      for (int s = 0; s < NSL; s++) begin m_rd[s] = 0; m_wr[s] = 0; end
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NSL; s++) begin m_rd[s] = 0; m_wr[s] = 0; end
    rst_n = 1'b0; win_end = 0; req_valid = 0; req_is_write = 0; req_take = 0;
    op_valid = '0; op_bypass = '0; op_reg = '0; op_slice = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state and idle
    apply(0, 0, 3'b111, 4, 5, 6, 0, 0, 0, 0, 1, 0, 0, "R9 idle no fit");
    apply(1, 0, 3'b011, 4, 5, 6, 0, 0, 0, 0, 0, 0, 1, "R3 reset two reads");
    apply(1, 0, 3'b111, 4, 5, 6, 0, 0, 0, 0, 0, 0, 0, "R3 three reads over limit");
    apply(1, 0, 3'b111, 4, 5, 6, 0, 0, 0, 3'b100, 0, 0, 1, "R1 bypass exempt");
    apply(1, 0, 3'b111, 4, 0, 6, 0, 0, 0, 0, 0, 0, 1, "R1 read-dedicated exempt");
    apply(1, 0, 3'b111, 4, 5, 6, 0, 1, 2, 0, 0, 0, 1, "R3 spread over slices");
    apply(1, 0, 3'b011, 4, 5, 6, 0, 0, 0, 0, 0, 0, 1, "R6 check did not consume");
    apply(1, 0, 3'b011, 4, 5, 6, 0, 0, 0, 0, 1, 0, 1, "R10 commit cycle sees old");
    apply(1, 0, 3'b001, 7, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 slice0 read exhausted");
    apply(1, 0, 3'b011, 7, 8, 0, 1, 1, 0, 0, 0, 0, 1, "R3 slice1 independent");
    apply(1, 1, 3'b001, 7, 0, 0, 0, 0, 0, 0, 1, 0, 1, "R4 write budget separate");
    apply(1, 1, 3'b001, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 slice0 write exhausted");
    apply(1, 0, 3'b001, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R8 exempt read on full slice");
    apply(1, 0, 3'b011, 4, 5, 0, 0, 0, 0, 0, 1, 1, 1, "R7 window cleared");
    apply(1, 0, 3'b011, 4, 5, 0, 0, 0, 0, 0, 0, 0, 1, "R7 same-cycle commit dropped");
    apply(1, 1, 3'b011, 3, 4, 0, 2, 2, 0, 3'b011, 0, 0, 0, "R2 bypass ignored for writes");
    apply(1, 1, 3'b011, 3, 15, 0, 2, 2, 0, 0, 0, 0, 1, "R2 write-dedicated exempt");
    apply(1, 0, 3'b011, 4, 5, 6, 3, 3, 3, 0, 1, 0, 1, "R9 masked operand free");
    apply(1, 0, 3'b001, 9, 0, 0, 3, 0, 0, 0, 1, 0, 0, "R6 slice3 now full");
    apply(1, 0, 3'b001, 9, 0, 0, 3, 0, 0, 0, 1, 0, 0, "R6 take without fit ignored");
    apply(1, 1, 3'b001, 15, 0, 0, 3, 0, 0, 0, 1, 1, 1, "R8 write-dedicated on zero limit");
    begin
      void'($urandom(32'h5EED_0101));
      for (int n = 0; n < 4000; n++) begin
        apply($urandom_range(0, 7) != 0, $urandom_range(0, 2) == 0,
              3'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
              2'($urandom), 2'($urandom), 2'($urandom),
              ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000,
              $urandom_range(0, 1) == 1, $urandom_range(0, 4) == 0,
              -1, "R3 random vs model");
      end
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule